// File: doc/BRIEF.md
# System Control Block Command and Status Controller

This block handles the host handshake of a LAN coprocessor. The host writes a 16-bit command word into a control block in shared memory and then pulses channel attention. The controller reads that word, decodes a command-unit field and a receive-unit field, and updates the state of both units. It writes the command word back as zero. It clears every event flag the host has acknowledged. It then writes a freshly packed 16-bit status word into the control block.

If the command unit is not suspended and no command list is loaded, the controller fetches the 32-bit list head pointer from the control block. It hands the pointer to the command sequencer together with a one-cycle start request. An interrupt output stays high while any event flag is set.

Attention pulses that arrive while a service is running are counted. Each one is serviced in turn, so no host request is lost.

The control block is word addressed from `scb_base`:
- `base+0` holds the status word.
- `base+1` holds the command word.
- `base+2` holds the low half of the list pointer.
- `base+3` holds the high half of the list pointer.

Memory reads return data on `mem_rdata` in the cycle after the request.

Top module: `scb_ctrl`

## Requirements
- R1: After reset the command unit is idle (code 0), the receive unit is suspended (code 1), all event flags are clear, `irq` is 0, `cmd_ptr` is all ones (null) and the memory port is inactive.
- R2: On each serviced attention the block reads the command word at `base+1` and later writes 0 to that same word.
- R3: The command-unit field is command bits 10:8. Code 1 makes the unit active (state 2). Code 4 makes it suspended (state 1) and sets the CNA flag (status bit 13). Code 0 changes nothing.
- R4: The receive-unit field is command bits 6:4. Codes 1 and 2 set the unit to state 0. Codes 3 and 4 set it to state 1 and set the RNR flag (status bit 12).
- R5: Command-unit codes 2, 3, 5, 6 and 7, and receive-unit codes 5, 6 and 7, leave their unit unchanged and raise no flag.
- R6: Command bits 15:12 acknowledge the flags at the same status positions (15 CX, 14 FR, 13 CNA, 12 RNR) by clearing them. A flag raised by the same command is set after the acknowledge is applied.
- R7: The status word written to `base+0` has the flags in bits 15:12, the command-unit state in bits 11:8, the receive-unit state in bits 7:4 and zero in bits 3:0.
- R8: Command bit 7 is a software reset. It is applied after the field decode and overrides it, returning the state of R1.
- R9: When the command unit is not suspended and the pointer is null, the block reads `base+2` (low) and `base+3` (high), presents the pointer on `cmd_ptr`, and pulses `cu_start` for exactly one cycle.
- R10: Attention pulses that arrive during a service are counted. Each one is serviced with its own status write.
- R11: `irq` is high exactly while at least one event flag is set.
- R12: When no pointer load is needed, the status write appears on the memory port in the fourth cycle after the edge that samples `ca`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ca | input | 1 | Channel attention, one pulse per request |
| scb_base | input | AW | Word address of the control block |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable for the access |
| mem_addr | output | AW | Word address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| cmd_ptr | output | PW | Command list pointer for the sequencer, all ones when null |
| cu_start | output | 1 | One-cycle start request to the command sequencer |
| irq | output | 1 | High while any event flag is set |

## Verification
A service without a pointer load follows a fixed timeline after the edge that samples `ca`:
- one cycle to leave idle;
- one cycle for the command read;
- one cycle for the decode;
- one cycle to clear the command word;
- the status write, which comes four cycles after that edge.

A pointer load inserts three more cycles, and `cu_start` follows the pointer capture by one register.

The timing scenario samples the memory port at the falling edge after exactly four rising edges. All other scenarios wait a margin longer than the longest service before reading the memory image or the output ports. Status writes and start pulses are counted by a monitor on the port, so back-to-back attention can be checked as exact counts.

// File: rtl/scb_ctrl.sv
module scb_ctrl #(
  parameter int AW = 16,
  parameter int PW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ca,
  input  logic [AW-1:0] scb_base,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic [PW-1:0] cmd_ptr,
  output logic          cu_start,
  output logic          irq
);
  localparam logic [PW-1:0] NULLP = '1;
  localparam logic [CW-1:0] PMAX  = '1;
  localparam logic [2:0] CU_IDLE = 3'd0, CU_SUSP = 3'd1, CU_ACT = 3'd2;
  localparam logic [2:0] RU_RDY = 3'd0, RU_SUSP = 3'd1;

  typedef enum logic [2:0] {S_IDLE, S_RCMD, S_DEC, S_CLR, S_RLO, S_RHI, S_LD, S_WST} st_t;

  st_t st;
  logic [CW-1:0] pend, pend_n;
  logic [2:0] cu_st, ru_st, cu_n, ru_n;
  logic [3:0] flags, flags_n;
  logic [PW-1:0] ptr;
  logic [15:0] lo_q;
  logic start_q, srst;

  assign cmd_ptr  = ptr;
  assign cu_start = start_q;
  assign irq      = |flags;

  always_comb begin
    pend_n = pend;
    if (ca && pend != PMAX) pend_n = pend_n + 1'b1;
    if (st == S_WST) pend_n = pend_n - 1'b1;
  end

  always_comb begin
    flags_n = flags & ~mem_rdata[15:12];
    cu_n = cu_st;
    ru_n = ru_st;
    srst = mem_rdata[7];
    case (mem_rdata[10:8])
      3'd1: cu_n = CU_ACT;
      3'd4: begin cu_n = CU_SUSP; flags_n[1] = 1'b1; end
      default: ;
    endcase
    case (mem_rdata[6:4])
      3'd1, 3'd2: ru_n = RU_RDY;
      3'd3, 3'd4: begin ru_n = RU_SUSP; flags_n[0] = 1'b1; end
      default: ;
    endcase
    if (srst) begin
      cu_n = CU_IDLE;
      ru_n = RU_SUSP;
      flags_n = '0;
    end
  end

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    mem_addr = scb_base;
    mem_wdata = '0;
    case (st)
      S_RCMD: begin mem_en = 1'b1; mem_addr = scb_base + AW'(1); end
      S_CLR:  begin mem_en = 1'b1; mem_we = 1'b1; mem_addr = scb_base + AW'(1); end
      S_RLO:  begin mem_en = 1'b1; mem_addr = scb_base + AW'(2); end
      S_RHI:  begin mem_en = 1'b1; mem_addr = scb_base + AW'(3); end
      S_WST:  begin
        mem_en = 1'b1; mem_we = 1'b1;
        mem_wdata = {flags, 1'b0, cu_st, 1'b0, ru_st, 4'b0000};
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      pend <= '0;
      cu_st <= CU_IDLE;
      ru_st <= RU_SUSP;
      flags <= '0;
      ptr <= NULLP;
      lo_q <= '0;
      start_q <= 1'b0;
    end else begin
      pend <= pend_n;
      start_q <= (st == S_LD);
      case (st)
        S_IDLE: if (pend != '0) st <= S_RCMD;
        S_RCMD: st <= S_DEC;
        S_DEC: begin
          cu_st <= cu_n;
          ru_st <= ru_n;
          flags <= flags_n;
          if (srst) ptr <= NULLP;
          st <= S_CLR;
        end
        S_CLR: st <= (cu_st != CU_SUSP && ptr == NULLP) ? S_RLO : S_WST;
        S_RLO: st <= S_RHI;
        S_RHI: begin lo_q <= mem_rdata; st <= S_LD; end
        S_LD: begin ptr <= PW'({mem_rdata, lo_q}); st <= S_WST; end
        S_WST: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic rd_cmd;
  assign rd_cmd = mem_en && !mem_we && mem_addr == scb_base + AW'(1);

  // R2
  cmd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_cmd, 2) |-> (mem_en && mem_we && mem_wdata == 16'h0 && mem_addr == $past(mem_addr, 2)));
  // R9
  start_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu_start |=> !cu_start);
  // R9
  start_unsusp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu_start |-> cu_st != CU_SUSP);
  // R3
  cu_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cu_st <= CU_ACT);
  // R10
  pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_addr == scb_base) |-> pend != '0);
  // R11
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(st == S_DEC));
endmodule

// File: tb/sim_scb_ctrl.sv
`timescale 1ns/1ps
module sim_scb_ctrl;
  localparam int AW = 16;
  localparam logic [AW-1:0] BASE = 16'h0010;

  logic clk = 0, rst_n = 0, ca = 0;
  logic mem_en, mem_we, cu_start, irq;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic [31:0] cmd_ptr;
  logic [15:0] mem [0:255];
  int n_chk = 0, n_fail = 0, n_stat = 0, n_start = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scb_ctrl #(.AW(AW), .PW(32), .CW(4)) u0 (
    .clk(clk), .rst_n(rst_n), .ca(ca), .scb_base(BASE),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cmd_ptr(cmd_ptr), .cu_start(cu_start), .irq(irq));

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else mem_rdata <= mem[mem_addr[7:0]];
    end
    if (rst_n && mem_en && mem_we && mem_addr == BASE) n_stat++;
    if (rst_n && cu_start) n_start++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic pulse_ca();
    @(negedge clk) ca = 1;
    @(negedge clk) ca = 0;
  endtask

  task automatic service(input logic [15:0] cmd);
    mem[BASE+1] = cmd;
    pulse_ca();
    repeat (14) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(irq == 0, "R1 irq", irq, 0);
    chk(cmd_ptr == 32'hFFFF_FFFF, "R1 ptr", cmd_ptr, 32'hFFFF_FFFF);
    chk(mem_en == 0, "R1 mem_en", mem_en, 0);
  endtask

  task automatic t_start();
    mem[BASE+2] = 16'h5678; mem[BASE+3] = 16'h1234;
    service(16'h0110);
    chk(mem[BASE] == 16'h0200, "R3 R4 R7 status", mem[BASE], 16'h0200);
    chk(mem[BASE+1] == 16'h0000, "R2 cmd cleared", mem[BASE+1], 0);
    chk(cmd_ptr == 32'h1234_5678, "R9 ptr", cmd_ptr, 32'h1234_5678);
    chk(n_start == 1, "R9 start count", n_start, 1);
  endtask

  task automatic t_abort();
    service(16'h0430);
    chk(mem[BASE] == 16'h3110, "R3 R4 abort", mem[BASE], 16'h3110);
    chk(irq == 1, "R11 irq set", irq, 1);
    chk(n_start == 1, "R9 no start while suspended", n_start, 1);
  endtask

  task automatic t_ack();
    service(16'h2000);
    chk(mem[BASE] == 16'h1110, "R6 ack CNA", mem[BASE], 16'h1110);
    chk(irq == 1, "R11 irq held", irq, 1);
  endtask

  task automatic t_unknown();
    service(16'h1750);
    chk(mem[BASE] == 16'h0110, "R5 unknown codes", mem[BASE], 16'h0110);
    chk(irq == 0, "R11 irq clear", irq, 0);
  endtask

  task automatic t_timing();
    mem[BASE+1] = 16'h0020;
    pulse_ca();
    repeat (4) @(negedge clk);
    chk(mem_en && mem_we && mem_addr == BASE, "R12 write slot", {mem_en, mem_we, mem_addr}, {2'b11, BASE});
    chk(mem_wdata == 16'h0100, "R12 R4 resume", mem_wdata, 16'h0100);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_ack_raise();
    service(16'h1030);
    chk(mem[BASE] == 16'h1110, "R6 ack then raise", mem[BASE], 16'h1110);
  endtask

  task automatic t_swreset();
    mem[BASE+2] = 16'hBEEF; mem[BASE+3] = 16'h00CA;
    service(16'h0480);
    chk(mem[BASE] == 16'h0010, "R8 reset status", mem[BASE], 16'h0010);
    chk(irq == 0, "R8 irq", irq, 0);
    chk(cmd_ptr == 32'h00CA_BEEF, "R8 R9 reload", cmd_ptr, 32'h00CA_BEEF);
    chk(n_start == 2, "R9 second start", n_start, 2);
  endtask

  task automatic t_multi();
    int s0;
    s0 = n_stat;
    mem[BASE+1] = 16'h0430;
    @(negedge clk) ca = 1;
    @(negedge clk) ca = 1;
    @(negedge clk) ca = 0;
    @(negedge clk) ca = 1;
    @(negedge clk) ca = 0;
    repeat (40) @(negedge clk);
    chk(n_stat - s0 == 3, "R10 three services", n_stat - s0, 3);
    chk(mem[BASE] == 16'h3110, "R10 final status", mem[BASE], 16'h3110);
    chk(mem[BASE+1] == 16'h0000, "R2 cleared after burst", mem[BASE+1], 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_start();
    t_abort();
    t_ack();
    t_unknown();
    t_timing();
    t_ack_raise();
    t_swreset();
    t_multi();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule